// File: doc/BRIEF.md
# I2C Word-Register Slave

This block is a target-only I2C port that gives a bus master access to a bank of 32-bit registers held outside the block. SCL and SDA are brought into the system clock domain, and every protocol decision is taken from sampled edges. The system clock must run at least 16 times faster than SCL, which covers 100 kbit/s, 400 kbit/s and 1 Mbit/s traffic. The block drives SDA only by pulling it low, through an output-enable. It never starts a transfer.

Each access moves one whole 32-bit word, split into four bytes. The least significant byte goes first, and within each byte the most significant bit goes first. A write names the device, then the register index, then up to four data bytes. A read first sets the register index with a write. It then issues a repeated START with the read bit and clocks out the four bytes. The master acknowledges the first three bytes and not the fourth.

The register file sits beside the block and is reached through a simple port. That port carries an index, a write word, a one-cycle write strobe and a combinational read word.

Top module: `i2c_regslave`

## Requirements
- R1: After reset, `sda_oe` is 0 and `reg_we` is 0, and the block does not pull SDA while no transfer is addressed to it.
- R2: The first byte after a START is 7 address bits followed by a direction bit, where 0 means write and 1 means read. When the address equals DEV_ADDR (default 7'h7F, so the bytes are 8'hFE and 8'hFF), the block holds SDA low through the ninth SCL pulse.
- R3: When the address byte does not match, the block acknowledges nothing and writes nothing until the next START.
- R4: In a write, the byte after the address byte is the register index. Only its low 7 bits are used and bit 7 is ignored. Four data bytes follow, carrying word bits 7:0, 15:8, 23:16 and 31:24 in that order. After the fourth byte, exactly one `reg_we` pulse of one cycle writes the assembled word to that index.
- R5: A write that ends with STOP after fewer than four data bytes leaves the register file untouched.
- R6: In a matched write, every received byte (index and data) is acknowledged by SDA low on the ninth pulse.
- R7: After an index-setting write, a repeated START with the read bit returns that register's word as four bytes, least significant byte first and each byte MSB first.
- R8: When the master answers a read byte with NACK (SDA high on the ninth pulse), the block releases SDA and stays off the bus until the next START or STOP.
- R9: A START seen at any point restarts the sequence at the address byte and discards any partly received word.
- R10: The block changes its SDA drive only while SCL is low.
- R11: Data bytes beyond the fourth in one write form further whole words. Each further word is committed to the same register index after its own fourth byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL level from the bus |
| sda_i | input | 1 | SDA level from the bus (wired-AND result) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr | output | 7 | Register index used for write and read |
| reg_wdata | output | 32 | Assembled word for the register file |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 32 | Word currently stored at `reg_addr` |

## Verification
A START can land while the engine is partway through a data byte. The restart of the address sequence then competes in the same sampled cycle with the byte and word assembly that the bit would otherwise advance. The bench provokes this with a repeated START three bits into the third data byte of a write, then sends a full write to a neighbouring index. The check is that the first register keeps its old word, the second gets exactly the new word, and the strobe count rises by one.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_ACKSET,
    S_ACKHOLD,
    S_RX,
    S_TX,
    S_TXACK,
    S_TXSAMP,
    S_TXNEXT,
    S_WAIT
  } rs_state_t;

endpackage

// File: rtl/i2c_rs_sync.sv
// Brings SCL and SDA into the clock domain and derives edges and bus conditions.
module i2c_rs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] lvl;
  logic [NLINES-1:0] prv;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= '1;
        prv[g] <= 1'b1;
      end else begin
        chain <= {chain[STAGES-2:0], raw[g]};
        prv[g] <= chain[STAGES-1];
      end
    end
    assign lvl[g] = chain[STAGES-1];
  end

  assign scl_s     = lvl[0];
  assign sda_s     = lvl[1];
  assign scl_rise  = lvl[0] & ~prv[0];
  assign scl_fall  = ~lvl[0] & prv[0];
  assign start_det = lvl[0] & prv[0] & prv[1] & ~lvl[1];
  assign stop_det  = lvl[0] & prv[0] & ~prv[1] & lvl[1];

endmodule

// File: rtl/i2c_rs_word.sv
// Byte-lane assembly of write words and byte selection of the captured read word.
module i2c_rs_word #(
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lane_we,
  input  logic [IW-1:0] wr_sel,
  input  logic [7:0]    wr_byte,
  input  logic          commit,
  input  logic          cap,
  input  logic [DW-1:0] rdata,
  input  logic [IW-1:0] rd_sel,
  output logic [7:0]    tx_byte,
  output logic [DW-1:0] wdata,
  output logic          we
);
  logic [7:0]    wbuf   [NB];
  logic [7:0]    rlane  [NB];
  logic [DW-1:0] rbuf;
  logic [DW-1:0] next_word;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic hit;
    assign hit = lane_we && (wr_sel == IW'(g));
    always_ff @(posedge clk) begin
      if (rst) wbuf[g] <= '0;
      else if (hit) wbuf[g] <= wr_byte;
    end
    assign next_word[g*8 +: 8] = hit ? wr_byte : wbuf[g];
    assign rlane[g] = rbuf[g*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rbuf  <= '0;
      wdata <= '0;
      we    <= 1'b0;
    end else begin
      we <= commit;
      if (commit) wdata <= next_word;
      if (cap) rbuf <= rdata;
    end
  end

  assign tx_byte = rlane[rd_sel];

  // R4: a completed word reaches the register port on the next cycle
  p_commit_we_r4: assert property (@(posedge clk) disable iff (rst) commit |=> we);
  // R4 / R11: each committed word is a single one-cycle strobe
  p_we_single_r4: assert property (@(posedge clk) disable iff (rst) we |=> !we);

endmodule

// File: rtl/i2c_rs_engine.sv
// Byte-level protocol engine: address match, acknowledge, receive and transmit.
module i2c_rs_engine
  import i2c_rs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h7F,
  parameter int AW = 7,
  parameter int NB = 4,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    tx_byte,
  output logic          sda_oe,
  output logic [AW-1:0] ptr,
  output logic          lane_we,
  output logic [IW-1:0] wr_sel,
  output logic [7:0]    wr_byte,
  output logic          commit,
  output logic          cap,
  output logic [IW-1:0] rd_sel
);
  rs_state_t     st;
  logic [2:0]    cnt;
  logic [6:0]    sh;
  logic [6:0]    txsh;
  logic          rw;
  logic          ptr_phase;
  logic [IW-1:0] idx;

  assign rd_sel = idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cnt       <= '0;
      sh        <= '0;
      txsh      <= '0;
      rw        <= 1'b0;
      ptr_phase <= 1'b0;
      idx       <= '0;
      ptr       <= '0;
      sda_oe    <= 1'b0;
      lane_we   <= 1'b0;
      wr_sel    <= '0;
      wr_byte   <= '0;
      commit    <= 1'b0;
      cap       <= 1'b0;
    end else begin
      lane_we <= 1'b0;
      commit  <= 1'b0;
      cap     <= 1'b0;
      if (stop_det) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        st     <= S_ADDR;
        cnt    <= '0;
        idx    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR: if (scl_rise) begin
            sh  <= {sh[5:0], sda_s};
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              if (sh == DEV_ADDR) begin
                rw        <= sda_s;
                ptr_phase <= ~sda_s;
                cap       <= sda_s;
                st        <= S_ACKSET;
              end else begin
                st <= S_WAIT;
              end
            end
          end
          S_ACKSET: if (scl_fall) begin
            sda_oe <= 1'b1;
            st     <= S_ACKHOLD;
          end
          S_ACKHOLD: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              txsh   <= tx_byte[6:0];
              sda_oe <= ~tx_byte[7];
              st     <= S_TX;
            end else begin
              sda_oe <= 1'b0;
              st     <= S_RX;
            end
          end
          S_RX: if (scl_rise) begin
            sh  <= {sh[5:0], sda_s};
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              st <= S_ACKSET;
              if (ptr_phase) begin
                ptr       <= {sh[AW-2:0], sda_s};
                ptr_phase <= 1'b0;
              end else begin
                lane_we <= 1'b1;
                wr_sel  <= idx;
                wr_byte <= {sh, sda_s};
                commit  <= (idx == IW'(NB - 1));
                idx     <= idx + IW'(1);
              end
            end
          end
          S_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) st <= S_TXACK;
            end else if (scl_fall) begin
              sda_oe <= ~txsh[6];
              txsh   <= {txsh[5:0], 1'b0};
            end
          end
          S_TXACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            st     <= S_TXSAMP;
          end
          S_TXSAMP: if (scl_rise) begin
            if (!sda_s) begin
              idx <= idx + IW'(1);
              st  <= S_TXNEXT;
            end else begin
              st <= S_WAIT;
            end
          end
          S_TXNEXT: if (scl_fall) begin
            txsh   <= tx_byte[6:0];
            sda_oe <= ~tx_byte[7];
            cnt    <= '0;
            st     <= S_TX;
          end
          S_IDLE, S_WAIT: ;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R1: no drive while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE) |-> !sda_oe);
  // R6 / R2: the acknowledge slot holds SDA low
  p_ack_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (st == S_ACKHOLD) |-> sda_oe);
  // R8 (also R3): parked engine never drives
  p_wait_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (st == S_WAIT) |-> !sda_oe);
  // R9: a START always restarts at the address byte
  p_start_addr_r9: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (st == S_ADDR));
  // R10: drive is steady while SCL was high
  p_sda_steady_r10: assert property (@(posedge clk) disable iff (rst)
    $past(scl_s) |-> $stable(sda_oe));

endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave #(
  parameter logic [6:0] DEV_ADDR = 7'h7F,
  parameter int AW = 7,
  parameter int DW = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  input  logic [DW-1:0] reg_rdata
);
  localparam int NB = DW / 8;
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;

  logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0]    tx_byte, wr_byte;
  logic          lane_we, commit, cap;
  logic [IW-1:0] wr_sel, rd_sel;

  i2c_rs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_rs_engine #(.DEV_ADDR(DEV_ADDR), .AW(AW), .NB(NB)) u_eng (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .tx_byte(tx_byte),
    .sda_oe(sda_oe), .ptr(reg_addr), .lane_we(lane_we), .wr_sel(wr_sel),
    .wr_byte(wr_byte), .commit(commit), .cap(cap), .rd_sel(rd_sel)
  );

  i2c_rs_word #(.DW(DW)) u_word (
    .clk(clk), .rst(rst), .lane_we(lane_we), .wr_sel(wr_sel),
    .wr_byte(wr_byte), .commit(commit), .cap(cap), .rdata(reg_rdata),
    .rd_sel(rd_sel), .tx_byte(tx_byte), .wdata(reg_wdata), .we(reg_we)
  );

endmodule

// File: tb/sim_i2c_regslave.sv
module sim_i2c_regslave;
  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe, reg_we;
  logic [6:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        sda_bus;

  logic [31:0] rf  [128];
  logic [31:0] exp_rf [128];
  int n_chk = 0, n_bad = 0, we_cnt = 0, r10_viol = 0;
  bit done = 0;
  logic oe_prev = 1'b0;

  always #2 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;
  assign reg_rdata = rf[reg_addr];

  i2c_regslave u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  initial for (int i = 0; i < 128; i++) begin rf[i] = '0; exp_rf[i] = '0; end

  always @(posedge clk) begin
    if (reg_we) begin
      rf[reg_addr] <= reg_wdata;
      we_cnt <= we_cnt + 1;
    end
  end

  // R10 monitor: drive changes seen while the bus clock is high
  always @(posedge clk) begin
    #1;
    if (!rst && scl_m && (sda_oe !== oe_prev)) r10_viol++;
    oe_prev = sda_oe;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic r);
    sda_m = b; wt(Q);
    scl_m = 1'b1; wt(4);
    r = sda_bus; wt(4);
    scl_m = 1'b0; wt(2);
  endtask

  task automatic start_c();
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b0; wt(2);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b1; wt(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_x(b[i], r);
    bit_x(1'b1, r);
    ack = ~r;
  endtask

  task automatic rbyte(input logic nack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin bit_x(1'b1, r); b[i] = r; end
    bit_x(nack, r);
  endtask

  task automatic wr_word(input logic [7:0] p, input logic [31:0] d);
    logic ack;
    start_c();
    wbyte(8'hFE, ack); chk("R2 write address ack", {31'd0, ack}, 32'd1);
    wbyte(p, ack);     chk("R6 index ack", {31'd0, ack}, 32'd1);
    for (int k = 0; k < 4; k++) begin
      wbyte(d[k*8 +: 8], ack); chk("R6 data ack", {31'd0, ack}, 32'd1);
    end
    stop_c();
    exp_rf[p[6:0]] = d;
  endtask

  task automatic rd_word(input logic [6:0] p, output logic [31:0] d);
    logic ack;
    logic [7:0] b;
    start_c();
    wbyte(8'hFE, ack); chk("R2 write address ack", {31'd0, ack}, 32'd1);
    wbyte({1'b0, p}, ack); chk("R6 index ack", {31'd0, ack}, 32'd1);
    start_c();
    wbyte(8'hFF, ack); chk("R2 read address ack", {31'd0, ack}, 32'd1);
    for (int k = 0; k < 4; k++) begin
      rbyte(k == 3, b);
      d[k*8 +: 8] = b;
    end
  endtask

  initial begin
    logic ack;
    logic [7:0] b;
    logic [31:0] d, d2;
    logic [6:0] p;
    int base;
    void'($urandom(32'h51ac3e07));
    wt(10);
    rst = 1'b0;
    wt(2);
    chk("R1 sda_oe after reset", {31'd0, sda_oe}, 32'd0);
    chk("R1 reg_we after reset", {31'd0, reg_we}, 32'd0);

    // R4: basic write
    wr_word(8'h0C, 32'h0000000A);
    wt(4);
    chk("R4 word written", rf[7'h0C], 32'h0000000A);
    // R7: read back
    rd_word(7'h0C, d); stop_c();
    chk("R7 read word", d, 32'h0000000A);

    // R4: index bit 7 ignored
    wr_word(8'h8C, 32'hA1B2C3D4);
    wt(4);
    chk("R4 index bit7 ignored", rf[7'h0C], 32'hA1B2C3D4);

    // R3: wrong device address
    base = we_cnt;
    start_c();
    wbyte(8'hA0, ack); chk("R3 no ack for foreign address", {31'd0, ack}, 32'd0);
    wbyte(8'h0C, ack); chk("R3 no ack after mismatch", {31'd0, ack}, 32'd0);
    for (int k = 0; k < 4; k++) wbyte(8'h55, ack);
    chk("R3 no ack on data", {31'd0, ack}, 32'd0);
    stop_c(); wt(4);
    chk("R3 register untouched", rf[7'h0C], exp_rf[7'h0C]);
    chk("R3 no strobe", we_cnt, base);

    // R5: partial word then STOP
    base = we_cnt;
    start_c();
    wbyte(8'hFE, ack); wbyte(8'h30, ack);
    for (int k = 0; k < 3; k++) wbyte(8'h77, ack);
    stop_c(); wt(4);
    chk("R5 partial discarded", rf[7'h30], exp_rf[7'h30]);
    chk("R5 no strobe", we_cnt, base);

    // R9: repeated START three bits into third data byte
    base = we_cnt;
    start_c();
    wbyte(8'hFE, ack); wbyte(8'h20, ack);
    wbyte(8'h11, ack); wbyte(8'h22, ack);
    bit_x(1'b1, ack); bit_x(1'b0, ack); bit_x(1'b1, ack);
    start_c();
    wbyte(8'hFE, ack); chk("R9 address ack after restart", {31'd0, ack}, 32'd1);
    wbyte(8'h21, ack);
    for (int k = 0; k < 4; k++) wbyte(8'h90 + 8'(k), ack);
    stop_c(); wt(4);
    exp_rf[7'h21] = 32'h93929190;
    chk("R9 interrupted register kept", rf[7'h20], exp_rf[7'h20]);
    chk("R9 following word written", rf[7'h21], 32'h93929190);
    chk("R9 single strobe", we_cnt, base + 1);

    // R11: eight data bytes -> two words to one index
    base = we_cnt;
    start_c();
    wbyte(8'hFE, ack); wbyte(8'h15, ack);
    for (int k = 0; k < 8; k++) begin
      wbyte(8'h40 + 8'(k), ack); chk("R11 extra byte ack", {31'd0, ack}, 32'd1);
    end
    stop_c(); wt(4);
    exp_rf[7'h15] = 32'h47464544;
    chk("R11 second word kept", rf[7'h15], 32'h47464544);
    chk("R11 two strobes", we_cnt, base + 2);

    // R8: after NACK, block stays off the bus
    rd_word(7'h15, d);
    chk("R7 read multiword register", d, 32'h47464544);
    rbyte(1'b1, b);
    chk("R8 released after NACK", {24'd0, b}, 32'h000000FF);
    stop_c();

    // Random write / read pairs
    for (int it = 0; it < 20; it++) begin
      p = 7'($urandom_range(0, 127));
      d2 = $urandom();
      wr_word({1'($urandom_range(0, 1)), p}, d2);
      wt(4);
      chk("R4 random write", rf[p], exp_rf[p]);
      rd_word(p, d); stop_c();
      chk("R7 random read", d, exp_rf[p]);
    end

    chk("R10 drive changes with SCL high", r10_viol, 0);

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule